// File: doc/BRIEF.md
# SPDIF Channel-Status and User-Bit Extractor

This block sits behind an SPDIF receiver front end that has already decoded the line code and found the preambles. Every decoded subframe arrives as a one-cycle strobe. The strobe comes with a channel flag, a flag that marks the first frame of a 192-frame block, and the channel-status and user bits of that subframe. The block counts frames from the block-start frame and captures the first 40 channel-status bits of each block, keeping the left and right channels apart. It makes each completed 40-bit word available through a byte-wide read port meant for a microcontroller register map.

Those 40 bits carry the fields a host most often needs: the audio/data indicator, the pre-emphasis code, the sampling-rate code and the clock-accuracy code. The block does not interpret them. It also forwards every raw user bit to a dedicated output, with a one-cycle ready pulse per bit, so an external controller can assemble user data itself.

Top module: `spdif_csx_top`

## Requirements
- R1: After reset, every read address returns 0x00, `user_rdy` is 0 and `user_data` is 0.
- R2: A left subframe (`sf_right`=0) with `sf_blk_start`=1 is frame 0. Each later left strobe is the next frame. Left status bit n is the `sf_cs` value of the left subframe of frame n.
- R3: Right status bit n is the `sf_cs` value of the first right subframe (`sf_right`=1) after the left subframe of frame n. `sf_blk_start` is ignored on right subframes.
- R4: A channel's readable word is replaced only in the cycle after that channel's bit 39 is strobed. Until then, reads return the previous complete word, or zero if there is none.
- R5: Status bits of frames 40 to 191 do not change either readable word.
- R6: A block start that arrives at any frame count, including before bit 39, restarts numbering at frame 0. The partially collected bits never reach the readable word.
- R7: Read port map: `rd_addr` 0 to 4 return left bits [8k+7:8k] for address k, and 5 to 9 return right bits for k-5. Bit n appears at bit n mod 8 of byte n/8, so bit 1 (audio/data), bits 3-5 (pre-emphasis), bits 24-27 (sample rate) and bits 28-29 (clock accuracy) keep their positions. Addresses 10 to 15 read 0x00.
- R8: For every strobe, `user_data` takes `sf_user` and `user_rdy` is 1 for exactly the next cycle, the same cycle in which `user_data` is updated. With no strobe, `user_rdy` is 0 and `user_data` holds.
- R9: Status bits are captured only while the frame count is valid. It becomes valid at a left block start and stays valid through frame 191. A left subframe past frame 191 with no block start invalidates it. Strobes while it is invalid leave both words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_stb | input | 1 | One-cycle strobe: a decoded subframe is present |
| sf_right | input | 1 | Subframe channel, 0 left, 1 right |
| sf_blk_start | input | 1 | Subframe belongs to frame 0 of a block |
| sf_cs | input | 1 | Channel-status bit of the subframe |
| sf_user | input | 1 | User bit of the subframe |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Read byte (combinational from the held words) |
| user_data | output | 1 | Last received user bit |
| user_rdy | output | 1 | One-cycle pulse with each new user bit |

## Verification
The blocks fed in use status patterns that differ per channel and per block, so a left/right swap or a frame-offset error shows up as a wrong byte. Frames 40 to 191 carry the inverse pattern, which exposes any capture past bit 39. A truncated block restarted at frame 20, right subframes sent before any block start, and frames beyond 191 with no block start show whether partial data is dropped and whether lock is handled. The user path alternates ones and zeros, which separates a late or stretched ready pulse from a correct one.

// File: rtl/spdif_csx_pkg.sv
package spdif_csx_pkg;
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   localparam int NUM_CH = 2;
endpackage

// File: rtl/spdif_csx_frame_ctr.sv
module spdif_csx_frame_ctr #(
   parameter int FRAMES = 192,
   parameter int IDX_W  = $clog2(FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb_i,
   input  logic             right_i,
   input  logic             bstart_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             idx_ok_o
);
   localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAMES - 1);

   logic [IDX_W-1:0] cnt_q;
   logic             lock_q;
   logic             left_stb;

   assign left_stb = stb_i & ~right_i;

   // index the current subframe belongs to
   always_comb begin
      idx_o    = '0;
      idx_ok_o = 1'b0;
      if (right_i) begin
         idx_o    = cnt_q;
         idx_ok_o = lock_q;
      end else if (bstart_i) begin
         idx_o    = '0;
         idx_ok_o = 1'b1;
      end else if (lock_q && (cnt_q != LAST_FRAME)) begin
         idx_o    = cnt_q + 1'b1;
         idx_ok_o = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
      end else if (left_stb) begin
         if (bstart_i) begin
            cnt_q  <= '0;
            lock_q <= 1'b1;
         end else if (lock_q) begin
            if (cnt_q == LAST_FRAME) begin
               lock_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assert_restart_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && !right_i && bstart_i) |=> (idx_ok_o && right_i) || (!right_i && bstart_i) ||
                                           (!right_i && idx_o == IDX_W'(1)));

   assert_lock_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && !right_i && !bstart_i && lock_q && cnt_q == LAST_FRAME) |=>
         !(right_i && idx_ok_o));
endmodule

// File: rtl/spdif_csx_cs_collect.sv
module spdif_csx_cs_collect #(
   parameter int CS_BITS = 40,
   parameter int IDX_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stb_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic               bit_i,
   output logic [CS_BITS-1:0] cs_o
);
   localparam int POS_W = $clog2(CS_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CS_BITS - 1);
   localparam logic [IDX_W-1:0] LIM_IDX  = IDX_W'(CS_BITS);

   logic [CS_BITS-1:0] sh_q;
   logic [CS_BITS-1:0] cs_q;
   logic [POS_W-1:0]   pos;
   logic               in_window;

   assign pos       = idx_i[POS_W-1:0];
   assign in_window = stb_i && (idx_i < LIM_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
         cs_q <= '0;
      end else if (in_window) begin
         sh_q[pos] <= bit_i;
         if (idx_i == LAST_IDX) begin
            cs_q <= {bit_i, sh_q[CS_BITS-2:0]};
         end
      end
   end

   assign cs_o = cs_q;

   assert_publish_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cs_q) |-> $past(stb_i && idx_i == LAST_IDX));
endmodule

// File: rtl/spdif_csx_user_tap.sv
module spdif_csx_user_tap (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic user_i,
   output logic user_data_o,
   output logic user_rdy_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         user_data_o <= 1'b0;
         user_rdy_o  <= 1'b0;
      end else begin
         user_rdy_o <= stb_i;
         if (stb_i) user_data_o <= user_i;
      end
   end

   assert_rdy_per_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> user_rdy_o);

   assert_rdy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> !user_rdy_o);

   assert_data_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !user_rdy_o |-> $stable(user_data_o));
endmodule

// File: rtl/spdif_csx_rd_mux.sv
module spdif_csx_rd_mux #(
   parameter int CS_BITS = 40,
   parameter int RD_W    = 8,
   parameter int ADDR_W  = 4
) (
   input  logic [CS_BITS-1:0] cs_l_i,
   input  logic [CS_BITS-1:0] cs_r_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [RD_W-1:0]    data_o
);
   localparam int BYTES = CS_BITS / RD_W;

   always_comb begin
      data_o = '0;
      for (int b = 0; b < BYTES; b++) begin
         if (addr_i == ADDR_W'(b))         data_o = cs_l_i[b*RD_W +: RD_W];
         if (addr_i == ADDR_W'(BYTES + b)) data_o = cs_r_i[b*RD_W +: RD_W];
      end
   end
endmodule

// File: rtl/spdif_csx_top.sv
module spdif_csx_top #(
   parameter int CS_BITS = 40,
   parameter int FRAMES  = 192,
   parameter int RD_W    = 8,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sf_stb,
   input  logic              sf_right,
   input  logic              sf_blk_start,
   input  logic              sf_cs,
   input  logic              sf_user,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [RD_W-1:0]   rd_data,
   output logic              user_data,
   output logic              user_rdy
);
   import spdif_csx_pkg::*;

   localparam int IDX_W = $clog2(FRAMES);

   generate
      if (FRAMES < CS_BITS) begin : g_bad_frames
         $error("FRAMES must be at least CS_BITS");
      end
      if ((CS_BITS % RD_W) != 0) begin : g_bad_rdw
         $error("CS_BITS must be a multiple of RD_W");
      end
      if (2 * (CS_BITS / RD_W) > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for both status words");
      end
   endgenerate

   logic [IDX_W-1:0]   idx;
   logic               idx_ok;
   chan_e              chan;
   logic [CS_BITS-1:0] cs_word [NUM_CH];

   assign chan = chan_e'(sf_right);

   spdif_csx_frame_ctr #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_i    (sf_stb),
      .right_i  (sf_right),
      .bstart_i (sf_blk_start),
      .idx_o    (idx),
      .idx_ok_o (idx_ok)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ch_stb;
      assign ch_stb = sf_stb && idx_ok && (chan == chan_e'(c));
      spdif_csx_cs_collect #(.CS_BITS(CS_BITS), .IDX_W(IDX_W)) u_col (
         .clk   (clk),
         .rst_n (rst_n),
         .stb_i (ch_stb),
         .idx_i (idx),
         .bit_i (sf_cs),
         .cs_o  (cs_word[c])
      );
   end

   spdif_csx_rd_mux #(.CS_BITS(CS_BITS), .RD_W(RD_W), .ADDR_W(ADDR_W)) u_rd (
      .cs_l_i (cs_word[0]),
      .cs_r_i (cs_word[1]),
      .addr_i (rd_addr),
      .data_o (rd_data)
   );

   spdif_csx_user_tap u_user (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb_i       (sf_stb),
      .user_i      (sf_user),
      .user_data_o (user_data),
      .user_rdy_o  (user_rdy)
   );
endmodule

// File: tb/spdif_csx_top_tb_top.sv
`timescale 1ns/1ps
module spdif_csx_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sf_stb = 1'b0, sf_right = 1'b0, sf_blk_start = 1'b0, sf_cs = 1'b0, sf_user = 1'b0;
   logic [3:0] rd_addr = 4'd0;
   logic [7:0] rd_data;
   logic       user_data, user_rdy;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spdif_csx_top dut_i (
      .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb), .sf_right(sf_right),
      .sf_blk_start(sf_blk_start), .sf_cs(sf_cs), .sf_user(sf_user),
      .rd_addr(rd_addr), .rd_data(rd_data), .user_data(user_data), .user_rdy(user_rdy)
   );

   // reference model: frame number per block, -1 when no valid block
   int         m_frame = -1;
   bit [39:0]  m_shadow [2];
   bit [39:0]  m_word [2];
   bit         m_udata = 1'b0;
   bit         m_urdy = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_frame = -1;
         m_shadow[0] = '0; m_shadow[1] = '0;
         m_word[0] = '0;   m_word[1] = '0;
         m_udata = 1'b0;   m_urdy = 1'b0;
      end else begin
         m_urdy = sf_stb;
         if (sf_stb) begin
            int n;
            int ch;
            m_udata = sf_user;
            ch = sf_right ? 1 : 0;
            if (!sf_right) begin
               if (sf_blk_start) m_frame = 0;
               else if (m_frame >= 0) begin
                  m_frame = m_frame + 1;
                  if (m_frame > 191) m_frame = -1;
               end
            end
            n = m_frame;
            if (n >= 0 && n < 40) begin
               m_shadow[ch][n] = sf_cs;
               if (n == 39) m_word[ch] = m_shadow[ch];
            end
         end
      end
   end

   function automatic logic [7:0] m_byte(input logic [3:0] a);
      if (a < 5) return m_word[0][a*8 +: 8];
      if (a < 10) return m_word[1][(a-5)*8 +: 8];
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model, away from the edge
   always @(posedge clk) begin
      #3;
      if (!done) begin
         chk("R7 rd_data vs model", {56'd0, rd_data}, {56'd0, m_byte(rd_addr)});
         chk("R8 user_data vs model", {63'd0, user_data}, {63'd0, m_udata});
         chk("R8 user_rdy vs model", {63'd0, user_rdy}, {63'd0, m_urdy});
      end
   end

   function automatic bit pat(input int ch, input int n, input int seed);
      return (((n * (seed + 2*ch + 3)) + seed) % 7) < 3;
   endfunction

   function automatic logic [39:0] pat_word(input int ch, input int seed);
      logic [39:0] w;
      for (int n = 0; n < 40; n++) w[n] = pat(ch, n, seed);
      return w;
   endfunction

   task automatic send_sub(input bit right, input bit bs, input bit cs, input bit ub);
      @(negedge clk);
      sf_stb = 1'b1; sf_right = right; sf_blk_start = bs; sf_cs = cs; sf_user = ub;
      rd_addr = rd_addr + 4'd1;
      @(negedge clk);
      sf_stb = 1'b0; sf_blk_start = 1'b0;
   endtask

   task automatic send_frame(input bit bs, input bit cl, input bit cr, input bit ul, input bit ur);
      send_sub(1'b0, bs, cl, ul);
      send_sub(1'b1, 1'b0, cr, ur);
   endtask

   task automatic read_word(input int ch, output logic [39:0] w);
      for (int b = 0; b < 5; b++) begin
         @(negedge clk);
         rd_addr = 4'(ch*5 + b);
         #1 w[b*8 +: 8] = rd_data;
      end
   endtask

   logic [39:0] w;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd_addr = 4'(a);
         #1 chk("R1 reset read", {56'd0, rd_data}, 64'd0);
      end
      chk("R1 reset user_rdy", {63'd0, user_rdy}, 64'd0);
      chk("R1 reset user_data", {63'd0, user_data}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: strobes before any block start are not captured
      for (int f = 0; f < 45; f++) send_frame(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      read_word(0, w); chk("R9 left before lock", {24'd0, w}, 64'd0);
      read_word(1, w); chk("R9 right before lock", {24'd0, w}, 64'd0);

      // R8 directed user path
      send_sub(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8 rdy after strobe", {63'd0, user_rdy}, 64'd1);
      chk("R8 data after strobe", {63'd0, user_data}, 64'd1);
      @(negedge clk);
      chk("R8 rdy single cycle", {63'd0, user_rdy}, 64'd0);
      chk("R8 data holds", {63'd0, user_data}, 64'd1);
      send_sub(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R8 data zero", {63'd0, user_data}, 64'd0);

      // block A, seed 1
      for (int f = 0; f < 39; f++)
         send_frame(f == 0, pat(0, f, 1), pat(1, f, 1), f[0], ~f[0]);
      read_word(0, w); chk("R4 left not before bit 39", {24'd0, w}, 64'd0);
      send_sub(1'b0, 1'b0, pat(0, 39, 1), 1'b1);
      read_word(0, w); chk("R2 left word block A", {24'd0, w}, {24'd0, pat_word(0, 1)});
      read_word(1, w); chk("R4 right waits for its bit 39", {24'd0, w}, 64'd0);
      send_sub(1'b1, 1'b1, pat(1, 39, 1), 1'b0);
      read_word(1, w); chk("R3 right word block A", {24'd0, w}, {24'd0, pat_word(1, 1)});
      for (int f = 40; f < 192; f++)
         send_frame(1'b0, ~pat(0, f % 40, 1), ~pat(1, f % 40, 1), 1'b1, 1'b0);
      read_word(0, w); chk("R5 left after frames 40-191", {24'd0, w}, {24'd0, pat_word(0, 1)});
      read_word(1, w); chk("R5 right after frames 40-191", {24'd0, w}, {24'd0, pat_word(1, 1)});

      // R6 truncated block then restart
      for (int f = 0; f < 20; f++) send_frame(f == 0, 1'b1, 1'b1, 1'b0, 1'b0);
      read_word(0, w); chk("R6 partial not published", {24'd0, w}, {24'd0, pat_word(0, 1)});
      for (int f = 0; f < 40; f++)
         send_frame(f == 0, pat(0, f, 4), pat(1, f, 4), 1'b0, 1'b1);
      read_word(0, w); chk("R6 left after restart", {24'd0, w}, {24'd0, pat_word(0, 4)});
      read_word(1, w); chk("R6 right after restart", {24'd0, w}, {24'd0, pat_word(1, 4)});

      // R7 unmapped addresses and field byte
      for (int a = 10; a < 16; a++) begin
         @(negedge clk); rd_addr = 4'(a);
         #1 chk("R7 unmapped address", {56'd0, rd_data}, 64'd0);
      end
      @(negedge clk); rd_addr = 4'd8;
      #1 chk("R7 right byte 3 (rate/accuracy)", {56'd0, rd_data}, {56'd0, pat_word(1, 4)[31:24]});

      // R9 lock loss after frame 191 without block start
      for (int f = 40; f < 192; f++) send_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int f = 0; f < 45; f++) send_frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      read_word(0, w); chk("R9 left after lock loss", {24'd0, w}, {24'd0, pat_word(0, 4)});
      read_word(1, w); chk("R9 right after lock loss", {24'd0, w}, {24'd0, pat_word(1, 4)});

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule